// File: doc/BRIEF.md
# Quarter-Wave Sine Demodulator

This block turns a one-bit oversampled bitstream, carrying a signal that is amplitude-modulated onto a 20 kHz carrier, into a signed baseband sample on every enabled clock. The bitstream arrives at 5.12 MHz, so one carrier cycle spans 256 samples. The block also produces the square wave that excites the sensor at the carrier rate. Because that square wave and the reference sine come from the same phase counter, the two stay in lock by construction.

The reference sine is rebuilt from a table that holds only the first quarter of the wave, as 64 unsigned magnitudes. Folding logic reverses the table index in the second and fourth quarters and flips the sign in the second half of the cycle. Multiplying a one-bit input by the reference reduces to a choice between the reference and its negation, so the datapath has no multiplier. Decimation filtering and phase alignment sit downstream and are not part of this block.

Top module: `qsine_demod`

## Requirements
- R1: While `rst_n` is low, `demod_o` is 0, `sense_o` is 1 and the phase is 0. Reset is asynchronous and active low.
- R2: The phase advances by one only on clocks where `sample_en` is 1. On clocks where `sample_en` is 0, `demod_o` and `sense_o` hold their values.
- R3: `sense_o` is 1 while the phase is 0 to 127 and 0 while the phase is 128 to 255. This gives a square wave of 256 enabled samples with a 50 % duty cycle.
- R4: The enabled sample taken at phase 255 returns the phase to 0, and in that same clock `sense_o` rises from 0 to 1.
- R5: For a sample taken at phase p with p below 128, the reference is round(sin(2π(p+0.5)/256)·32767). The phase p is the value before the clock edge. Phases 0 to 63 read the 64-entry table forward. Phases 64 to 127 read it at index 63 minus the low six phase bits.
- R6: `demod_o` is registered. One clock after an enabled sample, it equals the reference when `sd_bit` is 1 and the negated reference when `sd_bit` is 0.
- R7: For phases 128 to 255, the reference is the negation of the value found for phase p−128. This makes it round(sin(2π(p+0.5)/256)·32767), which is negative.
- R8: `demod_o` never takes the code −32768 (16'h8000). Every output lies in the range −32767 to +32767.
- R9: A reset applied in the middle of a carrier cycle restarts the next enabled sample at phase 0, with the reference for phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Qualifies a bitstream sample on this clock |
| sd_bit | input | 1 | One-bit modulated input; 1 means +1, 0 means −1 |
| demod_o | output | 16 | Signed demodulated sample, two's complement |
| sense_o | output | 1 | Carrier-rate square wave |

## Verification
Two events can land in the same clock. The first is the end-of-cycle wrap, where the phase returns to 0 and the square wave rises. The second is either a held sample, with the enable low, or an asynchronous reset. The bench lowers `sample_en` exactly at phase 255 to check that neither the wrap nor the edge happens early. It also pulses reset in the middle of a quarter to check that the next sample starts again at phase 0. Every result is judged against a reference that evaluates the sine directly over the whole circle, without folding, and multiplies it by the sign of the bit.

// File: rtl/qsd_pkg.sv
`timescale 1ns/1ps
package qsd_pkg;

  // Reference magnitude for table slot idx of a wave of `period` samples,
  // taken half a sample into the slot so quarter folding is exact.
  function automatic int sine_code(input int idx, input int period, input int mag_w);
    real ang;
    real s;
    ang = 2.0 * 3.141592653589793 * (real'(idx) + 0.5) / real'(period);
    s   = $sin(ang);
    return int'(s * real'((2 ** mag_w) - 1));
  endfunction

endpackage

// File: rtl/qsd_phase_gen.sv
`timescale 1ns/1ps
module qsd_phase_gen #(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic [PH_W-1:0] phase_o,
  output logic            sense_o,
  output logic            wrap_o
);
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic [PH_W-1:0] phase_q;

  // wrap: last sample of the cycle, square wave about to rise
  assign wrap_o  = en && (phase_q == PH_LAST);
  assign sense_o = ~phase_q[PH_W-1];
  assign phase_o = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (wrap_o)  phase_q <= '0;
    else if (en)      phase_q <= phase_q + PH_W'(1);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(phase_q));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_o) |=> (phase_q == $past(phase_q) + PH_W'(1)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (phase_q == '0) && $rose(sense_o));

  p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sense_o) |-> (phase_q == {1'b1, {(PH_W-1){1'b0}}}));

endmodule

// File: rtl/qsd_sine_rom.sv
`timescale 1ns/1ps
module qsd_sine_rom #(
  parameter int PH_W  = 8,
  parameter int MAG_W = 15
) (
  input  logic [PH_W-1:0]  phase_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             neg_o
);
  localparam int IDX_W = PH_W - 2;
  localparam int QLEN  = 2 ** IDX_W;
  localparam int FULL  = 4 * QLEN;

  logic [MAG_W-1:0] tbl [QLEN];

  for (genvar g = 0; g < QLEN; g++) begin : g_tbl
    localparam int CODE = qsd_pkg::sine_code(g, FULL, MAG_W);
    assign tbl[g] = MAG_W'(CODE);
  end

  logic             reverse;
  logic [IDX_W-1:0] idx;

  // second and fourth quarters walk the table backwards (~k == last-k)
  assign reverse = phase_i[PH_W-2];
  assign idx     = reverse ? ~phase_i[IDX_W-1:0] : phase_i[IDX_W-1:0];
  assign mag_o   = tbl[idx];
  assign neg_o   = phase_i[PH_W-1];

endmodule

// File: rtl/qsd_sign_sel.sv
`timescale 1ns/1ps
module qsd_sign_sel #(
  parameter int MAG_W = 15,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    sd_bit,
  input  logic [MAG_W-1:0]        mag_i,
  input  logic                    neg_i,
  output logic signed [OUT_W-1:0] demod_o
);
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic logic signed [OUT_W-1:0] widen(input logic [MAG_W-1:0] m);
    return $signed({{(OUT_W-MAG_W){1'b0}}, m});
  endfunction

  // negation clamped to keep the range symmetric
  function automatic logic signed [OUT_W-1:0] sat_neg(input logic signed [OUT_W-1:0] v);
    logic signed [OUT_W-1:0] n;
    n = -v;
    return (n == MOST_NEG) ? MOST_NEG + OUT_W'(1) : n;
  endfunction

  logic                    flip;
  logic signed [OUT_W-1:0] pos_val;
  logic signed [OUT_W-1:0] sel_val;

  // reference sign xor input sign: bit 0 stands for -1
  assign flip    = neg_i ^ ~sd_bit;
  assign pos_val = widen(mag_i);
  assign sel_val = flip ? sat_neg(pos_val) : pos_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  demod_o <= '0;
    else if (en) demod_o <= sel_val;
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    demod_o != MOST_NEG);

  p_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(demod_o));

  p_odd_sym_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flip && mag_i != '0) |=> demod_o < 0);

endmodule

// File: rtl/qsine_demod.sv
`timescale 1ns/1ps
module qsine_demod #(
  parameter int PH_W  = 8,
  parameter int MAG_W = 15,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             sd_bit,
  output logic [OUT_W-1:0] demod_o,
  output logic             sense_o
);
  logic [PH_W-1:0]         phase;
  logic                    wrap;
  logic [MAG_W-1:0]        mag;
  logic                    neg_half;
  logic signed [OUT_W-1:0] demod_s;

  qsd_phase_gen #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(sample_en),
    .phase_o(phase), .sense_o(sense_o), .wrap_o(wrap)
  );

  qsd_sine_rom #(.PH_W(PH_W), .MAG_W(MAG_W)) u_rom (
    .phase_i(phase), .mag_o(mag), .neg_o(neg_half)
  );

  qsd_sign_sel #(.MAG_W(MAG_W), .OUT_W(OUT_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .en(sample_en), .sd_bit(sd_bit),
    .mag_i(mag), .neg_i(neg_half), .demod_o(demod_s)
  );

  assign demod_o = demod_s;

  p_pos_quad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && sd_bit && !neg_half) |=> !demod_s[OUT_W-1]);

  p_neg_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && sd_bit && neg_half) |=> demod_s[OUT_W-1]);

  p_wrap_sense_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> sense_o);

endmodule

// File: tb/qsine_demod_tb_top.sv
`timescale 1ns/1ps
module qsine_demod_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic        sd_bit = 1'b0;
  logic [15:0] demod_o;
  logic        sense_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  qsine_demod dut_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sd_bit(sd_bit),
    .demod_o(demod_o), .sense_o(sense_o)
  );

  typedef struct {
    int    d;
    bit    s;
    string tag;
  } exp_t;

  exp_t q[$];
  int   ph_m   = 0;
  int   last_d = 0;

  // direct sine over the full circle, no folding
  function automatic int ref_val(input int p);
    real a;
    a = 2.0 * 3.141592653589793 * (real'(p) + 0.5) / 256.0;
    return int'($sin(a) * 32767.0);
  endfunction

  task automatic step(input bit en, input bit b);
    exp_t e;
    @(negedge clk);
    sample_en = en;
    sd_bit    = b;
    if (en) begin
      e.d = b ? ref_val(ph_m) : -ref_val(ph_m);
      if (ph_m == 255)     e.tag = "R4";
      else if (!b)         e.tag = "R6";
      else if (ph_m < 128) e.tag = "R5";
      else                 e.tag = "R7";
      ph_m = (ph_m + 1) % 256;
    end else begin
      e.d   = last_d;
      e.tag = "R2";
    end
    e.s    = (ph_m < 128);
    last_d = e.d;
    q.push_back(e);
  endtask

  // monitor: compare two time units after each edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if ($signed(demod_o) != e.d || sense_o != e.s) begin
        errors++;
        $display("FAIL %s: demod=%0d sense=%0b expected demod=%0d sense=%0b",
                 e.tag, $signed(demod_o), sense_o, e.d, e.s);
      end
      checks++;
      if (demod_o == 16'h8000) begin
        errors++;
        $display("FAIL R8: demod=%0d expected not -32768", $signed(demod_o));
      end
    end
  end

  task automatic check_reset(input string tag);
    checks++;
    if (demod_o != 16'h0000 || sense_o != 1'b1) begin
      errors++;
      $display("FAIL %s: demod=%0d sense=%0b expected demod=0 sense=1",
               tag, $signed(demod_o), sense_o);
    end
  endtask

  task automatic apply_reset(input string tag);
    @(negedge clk);
    rst_n     = 1'b0;
    sample_en = 1'b0;
    #1;
    check_reset(tag);
    ph_m   = 0;
    last_d = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R1: watchdog expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check_reset("R1");
    rst_n = 1'b1;

    // R5/R7: all ones, one full cycle
    for (int i = 0; i < 256; i++) step(1'b1, 1'b1);
    // R6: all zeros, one full cycle
    for (int i = 0; i < 256; i++) step(1'b1, 1'b0);
    // alternating bits
    for (int i = 0; i < 256; i++) step(1'b1, i[0]);

    // R2/R4: enable low exactly at phase 255
    for (int i = 0; i < 255; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);   // wrap sample R4
    step(1'b1, 1'b0);

    // pseudo-random bits with enable gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] != 4'h0, lfsr[7]);
    end

    // R9: reset in the middle of a quarter
    for (int i = 0; i < 37; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    apply_reset("R9");
    for (int i = 0; i < 300; i++) step(1'b1, i[1]);

    @(negedge clk);
    sample_en = 1'b0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule